// File: doc/BRIEF.md
# Interlaced Display Plane Scan-Out Address Generator

This block drives the read side of one display plane. It works out the frame-buffer address at which each displayed line starts. It also paces pixel fetches from memory and delivers the pixel stream to the output. It handles both progressive and interlaced scan-out. In interlaced operation the two fields read from separate start addresses with a common stride. Software chooses normal interlace or field replication by how it programs those registers. For normal interlace the second start is one line past the first and the stride is two line pitches, so the first field reads the even lines and the second field reads the odd ones. For field replication both starts are equal and the stride is one pitch, so the same stored frame is scanned out for both fields.

A two-bit multiplication control sets how pixels and lines are repeated. Code 0 repeats nothing. Code 1 doubles both pixels and lines, and is legal only in progressive mode. Code 2 is reserved. Code 3 doubles pixels only. When pixels are doubled, one source pixel is fetched for every two output slots, and each fetched pixel appears on two consecutive output slots. All configuration inputs are captured on the field strobe. A register write made in the middle of a field therefore takes effect only at the next field boundary.

Top module: `scan_plane_gen`

## Requirements
- R1: After reset, `line_addr`, `line_addr_vld`, `pix_out`, `pix_out_vld`, `fetch_req`, `mode_err` and `rsvd_flag` are 0, and `field_id` is 1. This makes the first interlaced field after reset field 0.
- R2: The configuration inputs are sampled only on a `vsync` strobe. A change between two strobes has no effect on addresses, repetition or flags until the next strobe.
- R3: In progressive mode (`cfg_interlace`=0), `field_id` is 0 and the address issued for the n-th `hsync` after `vsync` (n from 0) is `cfg_base_a + n*cfg_stride`, modulo 2^ADDR_W.
- R4: With `cfg_interlace`=1, `field_id` inverts on every `vsync` strobe. Field 0 uses `cfg_base_a` and field 1 uses `cfg_base_b`, each plus the line index times `cfg_stride`.
- R5: With both start addresses equal and interlace on, the two fields produce identical line address sequences.
- R6: With code 1 in progressive mode, each line address is issued on two consecutive `hsync` strobes before it advances by one stride.
- R7: Code 1 with interlace on raises `mode_err` for that field, and the field then behaves as code 0 (no line or pixel repetition). `mode_err` is 0 for every other combination.
- R8: Code 2 raises `rsvd_flag` for that field and behaves as code 0.
- R9: Without pixel doubling, `fetch_req` is high in every cycle in which `act` is high. The word that memory returns in the cycle after a request appears on `pix_out` one cycle later, with `pix_out_vld` high. Output lags `act` by two cycles.
- R10: With pixel doubling (code 3, or code 1 in progressive mode), `fetch_req` is high on the first `act` cycle after `hsync` and then on every second `act` cycle. Each fetched word appears on two consecutive valid output slots.
- R11: `line_addr_vld` is high for exactly the one cycle that follows an `hsync` strobe, and `line_addr` holds the new address during that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_base_a | input | ADDR_W | Start address for field 0 and for progressive frames |
| cfg_base_b | input | ADDR_W | Start address for field 1 |
| cfg_stride | input | ADDR_W | Address increment between fetched lines |
| cfg_interlace | input | 1 | 1 selects interlaced scan-out |
| cfg_mult | input | 2 | Repetition code: 0 none, 1 pixel+line, 2 reserved, 3 pixel only |
| vsync | input | 1 | Field start strobe, one cycle |
| hsync | input | 1 | Line start strobe, one cycle |
| act | input | 1 | Active output pixel slot |
| mem_pix | input | PIX_W | Pixel word from memory, valid the cycle after `fetch_req` |
| fetch_req | output | 1 | Request one source pixel this cycle |
| line_addr | output | ADDR_W | Start address of the current line |
| line_addr_vld | output | 1 | Pulse marking a new `line_addr` |
| pix_out | output | PIX_W | Output pixel |
| pix_out_vld | output | 1 | `pix_out` carries a pixel |
| field_id | output | 1 | Current field, 0 or 1 |
| mode_err | output | 1 | Illegal repetition/interlace combination in this field |
| rsvd_flag | output | 1 | Reserved repetition code in this field |

## Verification
The bench uses the default parameters: 32-bit addresses, 24-bit pixels and an 11-bit line index. With these widths the stride products stay well clear of wrap-around, and the addresses seen on the port can be compared directly with sums the bench computes itself. A table of six configurations covers progressive, normal interlace, field replication with pixel doubling, progressive line doubling, the illegal combination and the reserved code. Each configuration runs for two fields so that field alternation, including the progressive fall-back to field 0, is observed across configuration changes. Directed cases cover reset and a register write made mid-field.

// File: rtl/scan_pkg.sv
package scan_pkg;

  typedef enum logic [1:0] {
    MUL_NONE = 2'b00,
    MUL_BOTH = 2'b01,
    MUL_RSVD = 2'b10,
    MUL_PIX  = 2'b11
  } mul_mode_e;

  typedef struct packed {
    logic line_dbl;
    logic pix_dbl;
  } rep_sel_t;

  // Turns the raw code and the interlace bit into the repetition actually applied.
  function automatic rep_sel_t decode_rep(input logic [1:0] code, input logic il);
    rep_sel_t r;
    r = '{line_dbl: 1'b0, pix_dbl: 1'b0};
    case (mul_mode_e'(code))
      MUL_BOTH: if (!il) r = '{line_dbl: 1'b1, pix_dbl: 1'b1};
      MUL_PIX:  r.pix_dbl = 1'b1;
      default:  r = '{line_dbl: 1'b0, pix_dbl: 1'b0};
    endcase
    return r;
  endfunction

endpackage

// File: rtl/scan_frame_regs.sv
module scan_frame_regs
  import scan_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vsync,
  input  logic [ADDR_W-1:0] cfg_base_a,
  input  logic [ADDR_W-1:0] cfg_base_b,
  input  logic [ADDR_W-1:0] cfg_stride,
  input  logic              cfg_interlace,
  input  logic [1:0]        cfg_mult,
  output logic [ADDR_W-1:0] sh_base_a,
  output logic [ADDR_W-1:0] sh_base_b,
  output logic [ADDR_W-1:0] sh_stride,
  output logic              field_id,
  output logic              line_dbl,
  output logic              pix_dbl,
  output logic              mode_err,
  output logic              rsvd_flag
);

  rep_sel_t rep_next;
  logic     illegal_combo;
  logic     reserved_code;

  assign rep_next      = decode_rep(cfg_mult, cfg_interlace);
  assign illegal_combo = cfg_interlace && (mul_mode_e'(cfg_mult) == MUL_BOTH);
  assign reserved_code = (mul_mode_e'(cfg_mult) == MUL_RSVD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_base_a <= '0;
      sh_base_b <= '0;
      sh_stride <= '0;
      field_id  <= 1'b1;
      line_dbl  <= 1'b0;
      pix_dbl   <= 1'b0;
      mode_err  <= 1'b0;
      rsvd_flag <= 1'b0;
    end else if (vsync) begin
      sh_base_a <= cfg_base_a;
      sh_base_b <= cfg_base_b;
      sh_stride <= cfg_stride;
      field_id  <= cfg_interlace ? ~field_id : 1'b0;
      line_dbl  <= rep_next.line_dbl;
      pix_dbl   <= rep_next.pix_dbl;
      mode_err  <= illegal_combo;
      rsvd_flag <= reserved_code;
    end
  end

  // R7
  err_no_rep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_err |-> (!line_dbl && !pix_dbl));

  // R8
  rsvd_no_rep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsvd_flag |-> (!line_dbl && !pix_dbl));

  // R4
  field_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !vsync |=> $stable(field_id));

  // R6
  line_dbl_needs_pix_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_dbl |-> pix_dbl);

endmodule

// File: rtl/scan_line_gen.sv
module scan_line_gen #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned LINE_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vsync,
  input  logic              hsync,
  input  logic              field_id,
  input  logic [ADDR_W-1:0] sh_base_a,
  input  logic [ADDR_W-1:0] sh_base_b,
  input  logic [ADDR_W-1:0] sh_stride,
  input  logic              line_dbl,
  output logic [ADDR_W-1:0] line_addr,
  output logic              line_addr_vld
);

  function automatic logic [ADDR_W-1:0] line_start(
    input logic [ADDR_W-1:0] base,
    input logic [LINE_W-1:0] idx,
    input logic [ADDR_W-1:0] stride
  );
    return base + ADDR_W'(idx) * stride;
  endfunction

  logic [LINE_W-1:0] line_idx;
  logic              rep_q;
  logic              line_evt;
  logic              line_step;
  logic [ADDR_W-1:0] field_base;

  assign line_evt   = hsync && !vsync;
  assign line_step  = line_evt && (!line_dbl || rep_q);
  assign field_base = field_id ? sh_base_b : sh_base_a;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_idx      <= '0;
      rep_q         <= 1'b0;
      line_addr     <= '0;
      line_addr_vld <= 1'b0;
    end else begin
      line_addr_vld <= line_evt;
      if (vsync) begin
        line_idx <= '0;
        rep_q    <= 1'b0;
      end else if (line_evt) begin
        line_addr <= line_start(field_base, line_idx, sh_stride);
        rep_q     <= line_dbl ? ~rep_q : 1'b0;
        if (line_step) line_idx <= line_idx + 1'b1;
      end
    end
  end

  // R6
  dbl_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (line_evt && line_dbl && rep_q) |=> (line_addr == $past(line_addr)));

  // R11
  vld_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (line_addr_vld && !$past(hsync)) |-> 1'b0);

endmodule

// File: rtl/scan_pix_rep.sv
module scan_pix_rep #(
  parameter int unsigned PIX_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             vsync,
  input  logic             hsync,
  input  logic             act,
  input  logic             pix_dbl,
  input  logic [PIX_W-1:0] mem_pix,
  output logic             fetch_req,
  output logic [PIX_W-1:0] pix_out,
  output logic             pix_out_vld
);

  logic             phase_q;
  logic             rep_slot;
  logic             fetch_d;
  logic             rep_d;
  logic [PIX_W-1:0] hold_q;

  assign fetch_req = act && (!pix_dbl || !phase_q);
  assign rep_slot  = act && pix_dbl && phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q     <= 1'b0;
      fetch_d     <= 1'b0;
      rep_d       <= 1'b0;
      hold_q      <= '0;
      pix_out     <= '0;
      pix_out_vld <= 1'b0;
    end else begin
      if (vsync || hsync)      phase_q <= 1'b0;
      else if (act && pix_dbl) phase_q <= ~phase_q;
      fetch_d     <= fetch_req;
      rep_d       <= rep_slot;
      pix_out_vld <= fetch_d || rep_d;
      if (fetch_d) begin
        pix_out <= mem_pix;
        hold_q  <= mem_pix;
      end else if (rep_d) begin
        pix_out <= hold_q;
      end
    end
  end

  // R10
  fetch_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_req && pix_dbl && !hsync && !vsync) |=> !fetch_req);

  // R10
  rep_same_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rep_d |=> (pix_out == $past(pix_out)));

  // R9
  out_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req |=> ##1 pix_out_vld);

endmodule

// File: rtl/scan_plane_gen.sv
module scan_plane_gen #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned PIX_W  = 24,
  parameter int unsigned LINE_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cfg_base_a,
  input  logic [ADDR_W-1:0] cfg_base_b,
  input  logic [ADDR_W-1:0] cfg_stride,
  input  logic              cfg_interlace,
  input  logic [1:0]        cfg_mult,
  input  logic              vsync,
  input  logic              hsync,
  input  logic              act,
  input  logic [PIX_W-1:0]  mem_pix,
  output logic              fetch_req,
  output logic [ADDR_W-1:0] line_addr,
  output logic              line_addr_vld,
  output logic [PIX_W-1:0]  pix_out,
  output logic              pix_out_vld,
  output logic              field_id,
  output logic              mode_err,
  output logic              rsvd_flag
);

  logic [ADDR_W-1:0] sh_base_a;
  logic [ADDR_W-1:0] sh_base_b;
  logic [ADDR_W-1:0] sh_stride;
  logic              line_dbl;
  logic              pix_dbl;

  scan_frame_regs #(.ADDR_W(ADDR_W)) regs_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .vsync         (vsync),
    .cfg_base_a    (cfg_base_a),
    .cfg_base_b    (cfg_base_b),
    .cfg_stride    (cfg_stride),
    .cfg_interlace (cfg_interlace),
    .cfg_mult      (cfg_mult),
    .sh_base_a     (sh_base_a),
    .sh_base_b     (sh_base_b),
    .sh_stride     (sh_stride),
    .field_id      (field_id),
    .line_dbl      (line_dbl),
    .pix_dbl       (pix_dbl),
    .mode_err      (mode_err),
    .rsvd_flag     (rsvd_flag)
  );

  scan_line_gen #(.ADDR_W(ADDR_W), .LINE_W(LINE_W)) line_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .vsync         (vsync),
    .hsync         (hsync),
    .field_id      (field_id),
    .sh_base_a     (sh_base_a),
    .sh_base_b     (sh_base_b),
    .sh_stride     (sh_stride),
    .line_dbl      (line_dbl),
    .line_addr     (line_addr),
    .line_addr_vld (line_addr_vld)
  );

  scan_pix_rep #(.PIX_W(PIX_W)) pix_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .vsync       (vsync),
    .hsync       (hsync),
    .act         (act),
    .pix_dbl     (pix_dbl),
    .mem_pix     (mem_pix),
    .fetch_req   (fetch_req),
    .pix_out     (pix_out),
    .pix_out_vld (pix_out_vld)
  );

endmodule

// File: tb/scan_plane_gen_tb_top.sv
module scan_plane_gen_tb_top;

  localparam int unsigned AW = 32;
  localparam int unsigned PW = 24;
  localparam int unsigned NPIX = 6;

  typedef struct packed {
    logic          il;
    logic [1:0]    mm;
    logic [AW-1:0] ba;
    logic [AW-1:0] bb;
    logic [AW-1:0] st;
  } cfg_t;

  // progressive, normal interlace, replication+pixel dbl, line dbl, illegal, reserved
  localparam cfg_t CFGS [6] = '{
    '{1'b0, 2'b00, 32'h0000_1000, 32'h0000_0000, 32'h0000_0100},
    '{1'b1, 2'b00, 32'h0000_2000, 32'h0000_2080, 32'h0000_0100},
    '{1'b1, 2'b11, 32'h0000_3000, 32'h0000_3000, 32'h0000_0080},
    '{1'b0, 2'b01, 32'h0000_4000, 32'h0000_0000, 32'h0000_0040},
    '{1'b1, 2'b01, 32'h0000_6000, 32'h0000_6040, 32'h0000_0080},
    '{1'b0, 2'b10, 32'h0000_7000, 32'h0000_0000, 32'h0000_0020}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] cfg_base_a = '0, cfg_base_b = '0, cfg_stride = '0;
  logic          cfg_interlace = 1'b0;
  logic [1:0]    cfg_mult = 2'b00;
  logic          vsync = 1'b0, hsync = 1'b0, act = 1'b0;
  logic [PW-1:0] mem_pix = '0;
  logic          fetch_req, line_addr_vld, pix_out_vld, field_id, mode_err, rsvd_flag;
  logic [AW-1:0] line_addr;
  logic [PW-1:0] pix_out;

  int n_chk = 0;
  int n_fail = 0;
  int dv = 100;
  logic exp_field = 1'b1;
  logic done = 1'b0;
  logic [AW-1:0] first_seq [4];

  always #5 clk = ~clk;

  scan_plane_gen dut_i (
    .clk(clk), .rst_n(rst_n),
    .cfg_base_a(cfg_base_a), .cfg_base_b(cfg_base_b), .cfg_stride(cfg_stride),
    .cfg_interlace(cfg_interlace), .cfg_mult(cfg_mult),
    .vsync(vsync), .hsync(hsync), .act(act), .mem_pix(mem_pix),
    .fetch_req(fetch_req), .line_addr(line_addr), .line_addr_vld(line_addr_vld),
    .pix_out(pix_out), .pix_out_vld(pix_out_vld), .field_id(field_id),
    .mode_err(mode_err), .rsvd_flag(rsvd_flag)
  );

  // memory model: one-cycle read latency, each fetch returns the next sequence value
  always @(posedge clk) begin
    if (fetch_req) begin
      mem_pix <= PW'(dv);
      dv      <= dv + 1;
    end
  end

  task automatic check(input logic ok, input string req, input logic [63:0] act_v,
                       input logic [63:0] exp_v);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act_v, exp_v);
    end
  endtask

  task automatic pulse_vsync();
    vsync = 1'b1;
    @(negedge clk);
    vsync = 1'b0;
  endtask

  // issue one line; check address pulse and the pixel stream
  task automatic run_line(input logic [AW-1:0] exp_addr, input logic pdbl, input string req);
    int v0;
    int got;
    logic [PW-1:0] seq [2*NPIX];
    hsync = 1'b1;
    @(negedge clk);
    hsync = 1'b0;
    check(line_addr_vld == 1'b1, "R11", 64'(line_addr_vld), 64'd1);
    check(line_addr == exp_addr, req, 64'(line_addr), 64'(exp_addr));
    v0  = dv;
    got = 0;
    for (int i = 0; i < 2*NPIX; i++) begin
      act = (i < NPIX);
      @(negedge clk);
      if (i == 0) check(line_addr_vld == 1'b0, "R11", 64'(line_addr_vld), 64'd0);
      if (pix_out_vld && got < 2*NPIX) begin
        seq[got] = pix_out;
        got++;
      end
    end
    act = 1'b0;
    check(got == NPIX, pdbl ? "R10" : "R9", 64'(got), 64'(NPIX));
    for (int j = 0; j < NPIX; j++) begin
      int e;
      e = pdbl ? v0 + j/2 : v0 + j;
      if (j < got) check(seq[j] == PW'(e), pdbl ? "R10" : "R9", 64'(seq[j]), 64'(e));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(line_addr == '0 && !line_addr_vld && !pix_out_vld && pix_out == '0, "R1",
          64'(line_addr), 64'd0);
    check(!fetch_req && !mode_err && !rsvd_flag, "R1",
          64'({fetch_req, mode_err, rsvd_flag}), 64'd0);
    check(field_id == 1'b1, "R1", 64'(field_id), 64'd1);
    rst_n = 1'b1;
    @(negedge clk);

    for (int c = 0; c < 6; c++) begin
      logic ldbl, pdbl, ill, rsv, repl;
      ill  = CFGS[c].il && CFGS[c].mm == 2'b01;
      rsv  = CFGS[c].mm == 2'b10;
      ldbl = !CFGS[c].il && CFGS[c].mm == 2'b01;
      pdbl = ldbl || CFGS[c].mm == 2'b11;
      repl = CFGS[c].il && CFGS[c].ba == CFGS[c].bb;
      cfg_base_a    = CFGS[c].ba;
      cfg_base_b    = CFGS[c].bb;
      cfg_stride    = CFGS[c].st;
      cfg_interlace = CFGS[c].il;
      cfg_mult      = CFGS[c].mm;
      for (int f = 0; f < 2; f++) begin
        logic [AW-1:0] acc;
        pulse_vsync();
        exp_field = CFGS[c].il ? ~exp_field : 1'b0;
        check(field_id == exp_field, CFGS[c].il ? "R4" : "R3", 64'(field_id), 64'(exp_field));
        check(mode_err == ill, "R7", 64'(mode_err), 64'(ill));
        check(rsvd_flag == rsv, "R8", 64'(rsvd_flag), 64'(rsv));
        acc = exp_field ? CFGS[c].bb : CFGS[c].ba;
        for (int k = 0; k < 4; k++) begin
          if (k > 0 && (!ldbl || (k % 2) == 0)) acc = acc + CFGS[c].st;
          run_line(acc, pdbl, ldbl ? "R6" : (CFGS[c].il ? "R4" : "R3"));
          if (repl) begin
            if (f == 0) first_seq[k] = acc;
            else check(acc == first_seq[k], "R5", 64'(acc), 64'(first_seq[k]));
          end
        end
      end
    end

    // R2: a write made mid-field waits for the next field strobe
    cfg_interlace = 1'b0;
    cfg_mult      = 2'b00;
    cfg_base_a    = 32'h0000_5000;
    cfg_stride    = 32'h0000_0010;
    pulse_vsync();
    cfg_base_a = 32'h0000_9000;
    cfg_mult   = 2'b11;
    run_line(32'h0000_5000, 1'b0, "R2");
    run_line(32'h0000_5010, 1'b0, "R2");
    pulse_vsync();
    run_line(32'h0000_9000, 1'b1, "R2");
    // R8 reserved code written mid-field leaves the flag low until the strobe
    cfg_mult = 2'b10;
    @(negedge clk);
    check(rsvd_flag == 1'b0, "R2", 64'(rsvd_flag), 64'd0);
    pulse_vsync();
    check(rsvd_flag == 1'b1, "R8", 64'(rsvd_flag), 64'd1);
    run_line(32'h0000_9000, 1'b0, "R8");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule